// File: doc/BRIEF.md
# Paged Memory Mapper with Bypass

This block widens a 16-bit CPU address into a 21-bit physical address. The four most significant CPU address bits pick one of sixteen 12-bit page registers. The page value from that register takes the place of those four bits, and the lower twelve CPU bits pass through unchanged as the offset inside the page. The translation is purely combinational. The physical address follows the CPU address in the same cycle, and it follows a page register from the cycle after that register is written.

Software reaches the page registers and two control bits through a bit-addressed serial port. Each access names one bit by number and reads or writes that single bit, so the table takes up no memory space. After reset the block is in bypass: the CPU address comes out zero-extended, and every page register holds its own index. Mapping stays off until software sets the enable bit. A second control bit, the wide mode, assumes a word-only bus. In that mode the unused byte-select bit 0 is given up and one more page bit is used instead, which doubles the reachable physical space from 1 MB to 2 MB.

Top module: `page_mapper`

## Requirements
- R1: While reset is asserted and after it is released, `bypass` reads 1, both control bits read 0, and page register n holds the value n.
- R2: While mapping is disabled, `phys_addr` equals `cpu_addr` zero-extended to 21 bits, whatever the page registers hold.
- R3: Writing 1 to I/O bit 256 enables mapping and drives `bypass` to 0. Writing 0 to that bit returns the block to bypass.
- R4: With mapping enabled and wide mode off, `phys_addr` = {1'b0, page[7:0], cpu_addr[11:0]}, where page is the register indexed by `cpu_addr[15:12]`.
- R5: With mapping enabled and wide mode on (I/O bit 257 = 1), `phys_addr` = {page[8:0], cpu_addr[11:1], 1'b0}.
- R6: I/O bit number b = 16*i + k with k < 12 selects bit k of page register i. A write strobe stores `io_wdata` there at the clock edge, and the result shows on `phys_addr` from the following cycle.
- R7: `io_rdata` returns the selected page-register bit combinationally. Slots k = 12..15 read 0, and writes to them change nothing.
- R8: I/O bits 256 (enable) and 257 (wide) read back their values. Bits 258..511 read 0, and writes to them do not change the control bits or the outputs.
- R9: Asserting reset at any time returns the block to bypass and restores the identity table.
- R10: Page registers accept writes while the block is in bypass, and the written values take effect once mapping is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Logical CPU address |
| io_bit | input | 9 | Bit number for serial I/O access |
| io_wdata | input | 1 | Write data for the selected bit |
| io_wr | input | 1 | Write strobe for the selected bit |
| io_rdata | output | 1 | Read data of the selected bit |
| phys_addr | output | 21 | Translated physical address |
| bypass | output | 1 | High while mapping is disabled |

## Verification
A wrong page register bit changes `phys_addr` in the first cycle that presents a CPU address with the affected index. It is also visible at once on `io_rdata` when that bit is selected. A stuck control bit shows straight away: either `bypass` is wrong, or the page field and the low address bit take on the wrong layout. A write that lands in the wrong register or slot shows up as a readback mismatch on a neighbour, or as a reserved slot that no longer reads 0.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
    localparam int CA_W      = 16;
    localparam int IDX_W     = 4;
    localparam int OFS_W     = CA_W - IDX_W;
    localparam int N_MAP     = 1 << IDX_W;
    localparam int PAGE_W    = 12;
    localparam int SLOT_W    = 4;
    localparam int PA_W      = 21;
    localparam int NARROW_PG = PA_W - 1 - OFS_W;
    localparam int WIDE_PG   = PA_W - OFS_W;
    localparam int IOB_W     = IDX_W + SLOT_W + 1;
    localparam int CTL_BASE  = N_MAP << SLOT_W;
    localparam int CTL_BITS  = 2;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic wide;
        logic map_en;
    } ctl_t;
endpackage

// File: rtl/pgmap_table.sv
module pgmap_table
    import pgmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [SLOT_W-1:0] sel_slot,
    input  logic              wr_val,
    output logic              rd_bit,
    input  logic [IDX_W-1:0]  lk_idx,
    output page_t             lk_page
);
    typedef struct packed {
        page_t [N_MAP-1:0] pg;
    } tab_t;

    tab_t tab_d, tab_q;
    logic slot_hit;

    always_comb begin
        slot_hit = (int'(sel_slot) < PAGE_W);
        tab_d    = tab_q;
        if (wr_en && slot_hit) begin
            tab_d.pg[sel_idx][sel_slot] = wr_val;
        end
        rd_bit  = slot_hit ? tab_q.pg[sel_idx][sel_slot] : 1'b0;
        lk_page = tab_q.pg[lk_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_MAP; i++) begin
                tab_q.pg[i] <= PAGE_W'(i);
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    // R6
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && slot_hit) ##1 ($stable(sel_idx) && $stable(sel_slot))
        |-> rd_bit == $past(wr_val));

    // R7
    reserved_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !slot_hit) |=> $stable(tab_q));

    // R1
    identity_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> lk_page == PAGE_W'(lk_idx));
endmodule

// File: rtl/pgmap_ctl.sv
module pgmap_ctl
    import pgmap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic sel,
    input  logic wr_val,
    output logic rd_bit,
    output ctl_t ctl
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (sel) ctl_d.wide   = wr_val;
            else     ctl_d.map_en = wr_val;
        end
        rd_bit = sel ? ctl_q.wide : ctl_q.map_en;
        ctl    = ctl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    // R3
    enable_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.map_en) |-> $past(wr_en) && !$past(sel));

    // R8
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CA_W-1:0] ca,
    input  ctl_t            ctl,
    input  page_t           page,
    output logic [PA_W-1:0] pa
);
    always_comb begin
        if (!ctl.map_en) begin
            pa = PA_W'(ca);
        end else if (!ctl.wide) begin
            pa = {1'b0, page[NARROW_PG-1:0], ca[OFS_W-1:0]};
        end else begin
            pa = {page[WIDE_PG-1:0], ca[OFS_W-1:1], 1'b0};
        end
    end

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.map_en |-> (pa[CA_W-1:0] == ca) && (pa[PA_W-1:CA_W] == '0));

    // R4
    narrow_ofs_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.map_en && !ctl.wide) |-> pa[OFS_W-1:0] == ca[OFS_W-1:0] && !pa[PA_W-1]);

    // R5
    wide_even_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.map_en && ctl.wide) |-> !pa[0] && pa[OFS_W-1:1] == ca[OFS_W-1:1]);
endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import pgmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CA_W-1:0]  cpu_addr,
    input  logic [IOB_W-1:0] io_bit,
    input  logic             io_wdata,
    input  logic             io_wr,
    output logic             io_rdata,
    output logic [PA_W-1:0]  phys_addr,
    output logic             bypass
);
    logic              in_tab, in_ctl;
    logic              tab_rd, ctl_rd;
    logic [IDX_W-1:0]  sel_idx;
    logic [SLOT_W-1:0] sel_slot;
    page_t             lk_page;
    ctl_t              ctl;

    always_comb begin
        in_tab   = (int'(io_bit) < CTL_BASE);
        in_ctl   = (int'(io_bit) >= CTL_BASE) && (int'(io_bit) < CTL_BASE + CTL_BITS);
        sel_slot = io_bit[SLOT_W-1:0];
        sel_idx  = io_bit[SLOT_W +: IDX_W];
        io_rdata = in_tab ? tab_rd : (in_ctl ? ctl_rd : 1'b0);
        bypass   = !ctl.map_en;
    end

    pgmap_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (io_wr && in_tab),
        .sel_idx  (sel_idx),
        .sel_slot (sel_slot),
        .wr_val   (io_wdata),
        .rd_bit   (tab_rd),
        .lk_idx   (cpu_addr[CA_W-1 -: IDX_W]),
        .lk_page  (lk_page)
    );

    pgmap_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (io_wr && in_ctl),
        .sel    (io_bit[0]),
        .wr_val (io_wdata),
        .rd_bit (ctl_rd),
        .ctl    (ctl)
    );

    pgmap_xlate u_xlate (
        .clk  (clk),
        .rst  (rst),
        .ca   (cpu_addr),
        .ctl  (ctl),
        .page (lk_page),
        .pa   (phys_addr)
    );

    // R9
    reset_bypass_chk: assert property (@(posedge clk)
        $past(rst) |-> bypass);

    // R8
    reserved_io_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !in_tab && !in_ctl) |=> $stable(bypass));
endmodule

// File: tb/page_mapper_test.sv
module page_mapper_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] cpu_addr = '0;
    logic [8:0]  io_bit = '0;
    logic        io_wdata = 0;
    logic        io_wr = 0;
    logic        io_rdata;
    logic [20:0] phys_addr;
    logic        bypass;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    page_mapper uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic io_write(input int b, input bit v);
        @(negedge clk);
        io_bit = 9'(b); io_wdata = v; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic set_page(input int idx, input int val);
        for (int k = 0; k < 12; k++) io_write(idx*16 + k, val[k]);
    endtask

    task automatic read_page(input int idx, output int val);
        val = 0;
        for (int k = 0; k < 16; k++) begin
            io_bit = 9'(idx*16 + k); #1;
            val[k] = io_rdata;
        end
    endtask

    function automatic int exp_pa(input int a, input int pg, input bit en, input bit wd);
        if (!en) return a & 16'hFFFF;
        if (!wd) return ((pg & 8'hFF) << 12) | (a & 12'hFFF);
        return ((pg & 9'h1FF) << 12) | (a & 12'hFFE);
    endfunction

    task automatic pa_check(input int a, input int exp, input string req);
        cpu_addr = 16'(a); #1;
        check(int'(phys_addr) == exp, req, int'(phys_addr), exp);
    endtask

    task automatic t_reset_state();
        int v;
        @(negedge clk);
        check(bypass == 1, "R1 bypass", bypass, 1);
        read_page(5, v);  check(v == 5, "R1 identity p5", v, 5);
        read_page(15, v); check(v == 15, "R1 identity p15", v, 15);
        io_bit = 9'd256; #1; check(io_rdata == 0, "R1 enable bit", io_rdata, 0);
        io_bit = 9'd257; #1; check(io_rdata == 0, "R1 wide bit", io_rdata, 0);
        pa_check('hABCD, 'h0ABCD, "R2 passthru");
        pa_check('hFFFF, 'h0FFFF, "R2 passthru top");
    endtask

    task automatic t_bypass_write();
        int v;
        set_page(3, 'h2A7);
        @(negedge clk);
        pa_check('h3123, 'h03123, "R10 bypass ignores table");
        read_page(3, v); check(v == 'h2A7, "R7 readback", v, 'h2A7);
    endtask

    task automatic t_enable();
        io_write(256, 1);
        check(bypass == 0, "R3 bypass off", bypass, 0);
        pa_check('h3123, exp_pa('h3123, 'h2A7, 1, 0), "R10 R4 mapped p3");
        pa_check('h5FFF, exp_pa('h5FFF, 5, 1, 0), "R4 identity p5");
        set_page(0, 'hC81);
        @(negedge clk);
        pa_check('h0042, exp_pa('h0042, 'hC81, 1, 0), "R4 upper page bits dropped");
    endtask

    task automatic t_timing();
        @(negedge clk);
        cpu_addr = 16'h7000; io_bit = 9'(7*16); io_wdata = 0; io_wr = 1;
        #1 check(int'(phys_addr) == 'h07000, "R6 before edge", int'(phys_addr), 'h07000);
        @(posedge clk); #1;
        check(int'(phys_addr) == 'h06000, "R6 after edge", int'(phys_addr), 'h06000);
        @(negedge clk); io_wr = 0;
    endtask

    task automatic t_wide();
        set_page(9, 'h1F3);
        io_write(257, 1);
        io_bit = 9'd257; #1; check(io_rdata == 1, "R8 wide readback", io_rdata, 1);
        pa_check('h9ABD, exp_pa('h9ABD, 'h1F3, 1, 1), "R5 wide");
        pa_check('h3001, exp_pa('h3001, 'h2A7, 1, 1), "R5 wide p3");
        io_write(257, 0);
        pa_check('h9ABD, exp_pa('h9ABD, 'h1F3, 1, 0), "R4 narrow again");
    endtask

    task automatic t_ignored();
        int v;
        io_write(2*16 + 13, 1);
        io_bit = 9'(2*16 + 13); #1; check(io_rdata == 0, "R7 reserved slot", io_rdata, 0);
        read_page(2, v); check(v == 2, "R7 page intact", v, 2);
        io_write(300, 1);
        io_bit = 9'd300; #1; check(io_rdata == 0, "R8 reserved bit", io_rdata, 0);
        check(bypass == 0, "R8 state kept", bypass, 0);
        pa_check('h2010, exp_pa('h2010, 2, 1, 0), "R8 mapping kept");
        io_write(256, 0);
        check(bypass == 1, "R3 back to bypass", bypass, 1);
        pa_check('h3123, 'h03123, "R3 R2 passthru");
        io_write(256, 1);
    endtask

    task automatic t_reset_again();
        int v;
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        @(negedge clk);
        check(bypass == 1, "R9 bypass", bypass, 1);
        read_page(3, v); check(v == 3, "R9 identity", v, 3);
        pa_check('h3123, 'h03123, "R9 passthru");
        io_write(256, 1);
        pa_check('h3123, 'h03123, "R9 identity mapped");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        t_bypass_write();
        t_enable();
        t_timing();
        t_wide();
        t_ignored();
        t_reset_again();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule